// File: doc/BRIEF.md
# Video input sync conditioner

This block sits between an external video decoder and the scaler. It takes the decoder's raw timing strobes (vertical reference, horizontal reference, chroma reference, odd-field flag) and turns each into a clean, registered, active-high internal signal. Each strobe can be inverted independently, so decoders that drive active-low or active-high timing can both be used without changing the downstream logic.

The block also chooses where the display-active qualifier comes from: either a window produced by the internal register-programmed timing logic or the decoder's own data-enable pin. From the corrected vertical reference it derives an internal vertical sync pulse, one clock wide, that can be held back by a programmable number of eight-clock groups. Three configuration bits (bus width, YUV input, half-rate line clock) are not acted on here and are presented as status outputs for the blocks that use them.

All settings come in on one 16-bit configuration word: bits [3:0] invert the vertical, horizontal, chroma and field inputs (bit 0 to bit 3, 1 = invert), bit 4 selects the display-active source, bit 5 the bus width, bit 6 YUV input, bit 7 the half-rate line clock, and bits [15:8] hold the vertical sync delay in groups of eight clocks.

Top module: `vid_sync_cond`

## Requirements
- R1: Each reference output equals its input XOR its own invert bit (cfg bit 0 vertical, 1 horizontal, 2 chroma, 3 field), registered once, so it follows the input one clock later.
- R2: The display-active output is the external data-enable input when cfg bit 4 is 1 and the window input when it is 0, registered once.
- R3: With a delay field (cfg bits [15:8]) of 0, the vertical sync output is high in the same cycle in which the corrected vertical reference output first goes high.
- R4: With a delay field D greater than 0, the vertical sync pulse appears exactly 8*D cycles after the cycle in which the corrected vertical reference output goes high, and not in that cycle itself.
- R5: Each vertical reference rising edge yields exactly one vertical sync pulse, one clock wide.
- R6: A new rising edge of the corrected vertical reference during a pending delay cancels it and restarts the count from the new edge.
- R7: The delay value is captured at the rising edge; changing the delay field while a count is pending does not move the pulse.
- R8: The bus width (bit 5), YUV (bit 6) and half-rate clock (bit 7) configuration bits appear unchanged and without latency on their status outputs.
- R9: While reset is asserted all registered outputs are 0, whatever the inputs.
- R10: Only a rising edge of the corrected vertical reference starts a sync; with the vertical invert bit set, a rising input edge produces no pulse and a falling input edge does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input video clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_i | input | 16 | Configuration word (see bit layout above) |
| vref_i | input | 1 | Raw vertical reference from decoder |
| href_i | input | 1 | Raw horizontal reference from decoder |
| cref_i | input | 1 | Raw chroma reference from decoder |
| field_i | input | 1 | Raw odd-field flag from decoder |
| ext_de_i | input | 1 | External data-enable pin |
| win_de_i | input | 1 | Display-active window from register-programmed timing |
| vref_o | output | 1 | Corrected, registered vertical reference |
| href_o | output | 1 | Corrected, registered horizontal reference |
| cref_o | output | 1 | Corrected, registered chroma reference |
| field_o | output | 1 | Corrected, registered odd-field flag |
| de_o | output | 1 | Selected display-active, registered |
| vsync_o | output | 1 | Delayed internal vertical sync pulse, one clock wide |
| fmt16_o | output | 1 | 1 = 16-bit bus, 0 = 8-bit embedded-code bus |
| yuv_o | output | 1 | YUV input selected |
| clk_half_o | output | 1 | Half-rate line-locked clock selected |

## Verification
On every cycle the assertions check that each corrected reference follows its raw input and invert bit one clock later, that display-active follows the selected source one clock later, that a zero delay makes the sync pulse coincide with the vertical reference rise, and that a nonzero delay never does. The exact 8*D distance, the single-pulse count, the restart on a fresh edge, the capture of the delay value and the edge direction under inversion depend on histories of many cycles, so only the bench's scenarios show them, along with the status pass-through and the reset values.

// File: rtl/vsc_pkg.sv
package vsc_pkg;

  localparam int NREF   = 4;
  localparam int DLY_W  = 8;
  localparam int CFG_W  = DLY_W + 8;

  localparam int REF_V  = 0;
  localparam int REF_H  = 1;
  localparam int REF_C  = 2;
  localparam int REF_F  = 3;

  typedef struct packed {
    logic [DLY_W-1:0] vs_dly;
    logic             clk_half;
    logic             yuv;
    logic             fmt16;
    logic             de_ext;
    logic [NREF-1:0]  inv;
  } vsc_cfg_t;

endpackage

// File: rtl/vsc_rst_sync.sv
module vsc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign srst_n = sh_q[STAGES-1];

endmodule

// File: rtl/vsc_ref_cond.sv
module vsc_ref_cond #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw_i,
  input  logic [N-1:0] inv_i,
  output logic [N-1:0] cor_o,
  output logic [N-1:0] ref_q_o
);

  for (genvar g = 0; g < N; g++) begin : g_ch
    logic cor;
    logic ref_q;

    always_comb begin
      cor = raw_i[g] ^ inv_i[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ref_q <= 1'b0;
      end else begin
        ref_q <= cor;
      end
    end

    assign cor_o[g]   = cor;
    assign ref_q_o[g] = ref_q;
  end

endmodule

// File: rtl/vsc_de_sel.sv
module vsc_de_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic use_ext_i,
  input  logic ext_de_i,
  input  logic win_de_i,
  output logic de_o
);

  logic de_d;
  logic de_q;

  always_comb begin
    de_d = use_ext_i ? ext_de_i : win_de_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      de_q <= 1'b0;
    end else begin
      de_q <= de_d;
    end
  end

  assign de_o = de_q;

endmodule

// File: rtl/vsc_vs_delay.sv
module vsc_vs_delay #(
  parameter int DLY_W     = 8,
  parameter int STEP_LOG2 = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_cor_i,
  input  logic             ref_q_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             pulse_o
);

  localparam int CNT_W = DLY_W + STEP_LOG2;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             rise;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             pulse_d;
  logic             pulse_q;

  // rising edge of the corrected reference, seen one stage early
  always_comb begin
    rise = ref_cor_i & ~ref_q_i;
  end

  always_comb begin
    cnt_d   = cnt_q;
    pulse_d = 1'b0;
    cnt_en  = rise | (cnt_q != '0);
    if (rise) begin
      if (dly_i == '0) begin
        pulse_d = 1'b1;
        cnt_d   = '0;
      end else begin
        cnt_d = {dly_i, {STEP_LOG2{1'b0}}};
      end
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CNT_ONE;
      if (cnt_q == CNT_ONE) begin
        pulse_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= pulse_d;
    end
  end

  assign pulse_o = pulse_q;

endmodule

// File: rtl/vid_sync_cond.sv
module vid_sync_cond
  import vsc_pkg::*;
#(
  parameter int STEP_LOG2   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             vref_i,
  input  logic             href_i,
  input  logic             cref_i,
  input  logic             field_i,
  input  logic             ext_de_i,
  input  logic             win_de_i,
  output logic             vref_o,
  output logic             href_o,
  output logic             cref_o,
  output logic             field_o,
  output logic             de_o,
  output logic             vsync_o,
  output logic             fmt16_o,
  output logic             yuv_o,
  output logic             clk_half_o
);

  vsc_cfg_t        cfg;
  logic            rst_sn;
  logic [NREF-1:0] raw;
  logic [NREF-1:0] cor;
  logic [NREF-1:0] ref_q;

  assign cfg = vsc_cfg_t'(cfg_i);

  always_comb begin
    raw        = '0;
    raw[REF_V] = vref_i;
    raw[REF_H] = href_i;
    raw[REF_C] = cref_i;
    raw[REF_F] = field_i;
  end

  vsc_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sn)
  );

  vsc_ref_cond #(
    .N (NREF)
  ) u_ref (
    .clk     (clk),
    .rst_n   (rst_sn),
    .raw_i   (raw),
    .inv_i   (cfg.inv),
    .cor_o   (cor),
    .ref_q_o (ref_q)
  );

  vsc_de_sel u_de (
    .clk       (clk),
    .rst_n     (rst_sn),
    .use_ext_i (cfg.de_ext),
    .ext_de_i  (ext_de_i),
    .win_de_i  (win_de_i),
    .de_o      (de_o)
  );

  vsc_vs_delay #(
    .DLY_W     (DLY_W),
    .STEP_LOG2 (STEP_LOG2)
  ) u_vs (
    .clk       (clk),
    .rst_n     (rst_sn),
    .ref_cor_i (cor[REF_V]),
    .ref_q_i   (ref_q[REF_V]),
    .dly_i     (cfg.vs_dly),
    .pulse_o   (vsync_o)
  );

  assign vref_o     = ref_q[REF_V];
  assign href_o     = ref_q[REF_H];
  assign cref_o     = ref_q[REF_C];
  assign field_o    = ref_q[REF_F];
  assign fmt16_o    = cfg.fmt16;
  assign yuv_o      = cfg.yuv;
  assign clk_half_o = cfg.clk_half;

endmodule

// File: rtl/vsc_checks.sv
module vsc_checks (
  input logic        clk,
  input logic        rst_ok,
  input logic [15:0] cfg_i,
  input logic        vref_i,
  input logic        href_i,
  input logic        cref_i,
  input logic        field_i,
  input logic        ext_de_i,
  input logic        win_de_i,
  input logic        vref_o,
  input logic        href_o,
  input logic        cref_o,
  input logic        field_o,
  input logic        de_o,
  input logic        vsync_o
);

  logic armed;

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      armed <= 1'b0;
    end else begin
      armed <= 1'b1;
    end
  end

  // R1: each channel follows raw input and its invert bit one clock later
  assert_vref_pol_R1: assert property (@(posedge clk) disable iff (!armed)
    vref_o == $past(vref_i ^ cfg_i[0]));
  assert_href_pol_R1: assert property (@(posedge clk) disable iff (!armed)
    href_o == $past(href_i ^ cfg_i[1]));
  assert_cref_pol_R1: assert property (@(posedge clk) disable iff (!armed)
    cref_o == $past(cref_i ^ cfg_i[2]));
  assert_field_pol_R1: assert property (@(posedge clk) disable iff (!armed)
    field_o == $past(field_i ^ cfg_i[3]));

  // R2: display-active follows the selected source one clock later
  assert_de_src_R2: assert property (@(posedge clk) disable iff (!armed)
    de_o == $past(cfg_i[4] ? ext_de_i : win_de_i));

  // R3: zero delay puts the pulse on the reference rise
  assert_zero_dly_R3: assert property (@(posedge clk) disable iff (!armed)
    ($rose(vref_o) && ($past(cfg_i[15:8]) == 8'd0)) |-> vsync_o);

  // R4: nonzero delay never fires on the rise itself
  assert_no_early_R4: assert property (@(posedge clk) disable iff (!armed)
    ($rose(vref_o) && ($past(cfg_i[15:8]) != 8'd0)) |-> !vsync_o);

endmodule

bind vid_sync_cond vsc_checks u_vsc_checks (
  .clk      (clk),
  .rst_ok   (rst_sn),
  .cfg_i    (cfg_i),
  .vref_i   (vref_i),
  .href_i   (href_i),
  .cref_i   (cref_i),
  .field_i  (field_i),
  .ext_de_i (ext_de_i),
  .win_de_i (win_de_i),
  .vref_o   (vref_o),
  .href_o   (href_o),
  .cref_o   (cref_o),
  .field_o  (field_o),
  .de_o     (de_o),
  .vsync_o  (vsync_o)
);

// File: tb/tb_vid_sync_cond.sv
module tb_vid_sync_cond;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cfg;
  logic        vref_i, href_i, cref_i, field_i, ext_de_i, win_de_i;
  logic        vref_o, href_o, cref_o, field_o, de_o, vsync_o;
  logic        fmt16_o, yuv_o, clk_half_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  vid_sync_cond dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_i      (cfg),
    .vref_i     (vref_i),
    .href_i     (href_i),
    .cref_i     (cref_i),
    .field_i    (field_i),
    .ext_de_i   (ext_de_i),
    .win_de_i   (win_de_i),
    .vref_o     (vref_o),
    .href_o     (href_o),
    .cref_o     (cref_o),
    .field_o    (field_o),
    .de_o       (de_o),
    .vsync_o    (vsync_o),
    .fmt16_o    (fmt16_o),
    .yuv_o      (yuv_o),
    .clk_half_o (clk_half_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // raise vref (non-inverted) and record where pulses land; idx 0 = vref_o high
  task automatic run_delay(input int d, input string req);
    int cnt = 0;
    int pos = -1;
    cfg[15:8] = 8'(d);
    cfg[0]    = 1'b0;
    vref_i    = 1'b0;
    repeat (4) step();
    vref_i = 1'b1;
    step();
    for (int idx = 0; idx <= 8 * d + 12; idx++) begin
      if (vsync_o) begin
        cnt++;
        if (pos < 0) pos = idx;
      end
      if (idx == 3) vref_i = 1'b0;
      step();
    end
    chk(pos == 8 * d, req, pos, 8 * d);
    chk(cnt == 1, "R5 single pulse", cnt, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int cnt;
    int pos;
    rst_n = 1'b0;
    cfg = 16'h0;
    {vref_i, href_i, cref_i, field_i, ext_de_i, win_de_i} = 6'b111111;
    repeat (4) step();
    // R9: reset holds outputs low
    chk({vref_o, href_o, cref_o, field_o, de_o, vsync_o} == 6'b0, "R9 reset",
        int'({vref_o, href_o, cref_o, field_o, de_o, vsync_o}), 0);
    {vref_i, href_i, cref_i, field_i, ext_de_i, win_de_i} = 6'b0;
    rst_n = 1'b1;
    repeat (6) step();
    chk({vref_o, href_o, cref_o, field_o, de_o, vsync_o} == 6'b0, "R9 after release",
        int'({vref_o, href_o, cref_o, field_o, de_o, vsync_o}), 0);

    // R1: all invert settings x all input patterns
    for (int inv = 0; inv < 16; inv++) begin
      for (int pat = 0; pat < 16; pat++) begin
        cfg[3:0] = 4'(inv);
        {field_i, cref_i, href_i, vref_i} = 4'(pat);
        step();
        chk({field_o, cref_o, href_o, vref_o} == 4'(pat ^ inv), "R1 polarity",
            int'({field_o, cref_o, href_o, vref_o}), pat ^ inv);
      end
    end
    cfg[3:0] = 4'h0;
    {field_i, cref_i, href_i, vref_i} = 4'h0;

    // R2: source select sweep
    for (int m = 0; m < 8; m++) begin
      cfg[4]   = m[2];
      ext_de_i = m[1];
      win_de_i = m[0];
      step();
      chk(de_o == (m[2] ? m[1] : m[0]), "R2 de source", int'(de_o),
          int'(m[2] ? m[1] : m[0]));
    end

    // R8: status pass-through, no latency
    for (int b = 0; b < 8; b++) begin
      cfg[7:5] = 3'(b);
      #1;
      chk({clk_half_o, yuv_o, fmt16_o} == 3'(b), "R8 status",
          int'({clk_half_o, yuv_o, fmt16_o}), b);
    end
    cfg[7:5] = 3'b0;

    // R3 / R4 / R5: delay sweep
    run_delay(0, "R3 zero delay");
    run_delay(1, "R4 delay 1");
    run_delay(2, "R4 delay 2");
    run_delay(3, "R4 delay 3");
    run_delay(5, "R4 delay 5");
    run_delay(8, "R4 delay 8");
    run_delay(255, "R4 delay 255");

    // R6: second rise during pending count restarts it
    cfg[15:8] = 8'd2;
    vref_i = 1'b0;
    repeat (4) step();
    vref_i = 1'b1;
    step();
    cnt = 0;
    pos = -1;
    for (int idx = 0; idx <= 45; idx++) begin
      if (vsync_o) begin
        cnt++;
        if (pos < 0) pos = idx;
      end
      if (idx == 4)  vref_i = 1'b0;
      if (idx == 8)  vref_i = 1'b1;
      if (idx == 12) vref_i = 1'b0;
      step();
    end
    chk(pos == 25, "R6 restart position", pos, 25);
    chk(cnt == 1, "R6 restart count", cnt, 1);

    // R7: delay captured at the edge
    cfg[15:8] = 8'd3;
    repeat (4) step();
    vref_i = 1'b1;
    step();
    cnt = 0;
    pos = -1;
    for (int idx = 0; idx <= 40; idx++) begin
      if (vsync_o) begin
        cnt++;
        if (pos < 0) pos = idx;
      end
      if (idx == 0) cfg[15:8] = 8'd0;
      if (idx == 3) vref_i = 1'b0;
      step();
    end
    chk(pos == 24, "R7 captured delay", pos, 24);
    chk(cnt == 1, "R7 pulse count", cnt, 1);

    // R10: inverted vertical reference, edge direction
    cfg[15:8] = 8'd0;
    cfg[0]    = 1'b1;
    vref_i    = 1'b0;
    repeat (5) step();
    vref_i = 1'b1;
    step();
    cnt = 0;
    for (int idx = 0; idx < 6; idx++) begin
      if (vsync_o) cnt++;
      step();
    end
    chk(cnt == 0, "R10 no pulse on input rise", cnt, 0);
    vref_i = 1'b0;
    step();
    chk(vsync_o == 1'b1, "R10 pulse on input fall", int'(vsync_o), 1);
    chk(vref_o == 1'b1, "R10 corrected level", int'(vref_o), 1);
    step();
    chk(vsync_o == 1'b0, "R5 pulse width", int'(vsync_o), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule